// File: doc/BRIEF.md
# Byte/Word Stack Pointer Unit

This unit keeps the top-of-stack address for a small 8-bit processor core. The stack grows toward lower addresses. The core sends one strobe per operation: single-byte push, single-byte pop, two-byte push (a call or interrupt entry saving a return address), and two-byte pop (a return). For each strobe the unit sets the pointer to its new value. For each byte moved it presents one data-memory address, with a valid flag and a direction flag, in the same cycle as that byte's access.

A push writes at the current pointer and then lowers the pointer by one. A pop raises the pointer by one and then reads at the raised address. A two-byte transfer takes two consecutive cycles. While the second cycle runs, a busy output is high. Software reads and writes the pointer as two byte-wide registers on an I/O bus. A write to either byte takes priority over any stack activity in the same cycle.

The unit raises a low-stack flag while the pointer sits at or below 0x60. It also keeps a sticky error bit that records any cycle in which the core asserts more than one strobe. A parameter sets how many pointer bits are implemented. The bits above that count read as zero and ignore writes.

Top module: `stackPointerUnit`

## Requirements
- R1: After reset the pointer is 0x0000, the error bit is 0, busy is 0 and no memory access is presented.
- R2: A single-byte push presents memAddr equal to the current pointer, with memValid=1 and memWrite=1, in the strobe cycle. The pointer is one lower after that clock edge.
- R3: A single-byte pop presents memAddr equal to the pointer plus one, with memValid=1 and memWrite=0, in the strobe cycle. The pointer is one higher after that clock edge.
- R4: A two-byte push presents memAddr equal to SP in the strobe cycle and SP-1 in the following cycle, both as writes. Busy is high during the second cycle, and the pointer ends 2 lower.
- R5: A two-byte pop presents SP+1 in the strobe cycle and SP+2 in the following cycle, both as reads. Busy is high during the second cycle, and the pointer ends 2 higher.
- R6: With ioWrEn=1, ioSel=1 selects bits 15..8 and ioSel=0 selects bits 7..0. The selected byte takes ioWrData at the next clock edge. ioRdData always shows the byte that ioSel selects.
- R7: In a cycle with ioWrEn=1, no memory access is presented and every strobe is dropped. If a two-byte transfer was in its second cycle, its remaining step is cancelled.
- R8: Pointer arithmetic and the presented addresses wrap modulo 2^16. A push at 0x0000 leaves 0xFFFF, and a pop at 0xFFFF addresses 0x0000.
- R9: A cycle with more than one strobe high performs no access and leaves the pointer unchanged. It sets the error bit, and only reset clears that bit.
- R10: lowStack is 1 exactly when the pointer is at or below 0x60.
- R11: Strobes that arrive during the second cycle of a two-byte transfer are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| pushByte | input | 1 | Single-byte push strobe |
| popByte | input | 1 | Single-byte pop strobe |
| pushWord | input | 1 | Two-byte push strobe (call, interrupt entry) |
| popWord | input | 1 | Two-byte pop strobe (return) |
| ioWrEn | input | 1 | I/O write enable for the pointer byte registers |
| ioSel | input | 1 | Byte select: 1 high byte, 0 low byte |
| ioWrData | input | 8 | I/O write data |
| ioRdData | output | 8 | Selected pointer byte |
| memAddr | output | 16 | Data-memory address of the current stack byte |
| memValid | output | 1 | A stack byte access is presented this cycle |
| memWrite | output | 1 | 1 for a push access, 0 for a pop access |
| spValue | output | 16 | Current pointer value |
| busy | output | 1 | Second cycle of a two-byte transfer |
| lowStack | output | 1 | Pointer at or below 0x60 |
| multiErr | output | 1 | Sticky flag for conflicting strobes |

## Verification
The bench aims at the asymmetry between push and pop addressing. A design that pre-decremented, or that post-incremented, would put every address off by one. It also checks the second cycle of a two-byte transfer. A design that stepped by two at once would present the same address twice, or skip the middle byte. The bench drives I/O writes into the strobe cycle and into the second cycle. A design that let the stack step win would lose the software value, and one that kept the pending step would corrupt the pointer just loaded. Conflicting strobes, strobes during busy, the wrap at 0x0000 and 0xFFFF, and the 0x60/0x61 boundary of the low-stack flag are each hit directly. A long mixed sequence then follows.

// File: rtl/stackPkg.sv
package stackPkg;

  // Strobes from the control module to the datapath for one cycle.
  typedef struct packed {
    logic load;    // software byte write
    logic stepDn;  // push step: access at SP, then SP-1
    logic stepUp;  // pop step: SP+1, then access there
    logic memEn;   // a memory byte access is presented
  } stackCtl_t;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_DN2  = 2'd1,
    PH_UP2  = 2'd2
  } stackPhase_e;

endpackage

// File: rtl/stackPtrCtrl.sv
module stackPtrCtrl
  import stackPkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      pushByte,
  input  logic      popByte,
  input  logic      pushWord,
  input  logic      popWord,
  input  logic      ioWrEn,
  output stackCtl_t ctl,
  output logic      busy,
  output logic      multiErr
);

  stackPhase_e phase, phaseNext;
  logic [2:0]  strobeCount;
  logic        oneStrobe;
  logic        clash;
  logic        errReg;

  always_comb begin
    strobeCount = 3'(pushByte) + 3'(popByte) + 3'(pushWord) + 3'(popWord);
    oneStrobe   = (strobeCount == 3'd1);
    clash       = (strobeCount > 3'd1);
  end

  always_comb begin
    ctl       = '0;
    phaseNext = PH_IDLE;
    if (ioWrEn) begin
      ctl.load = 1'b1;            // software wins, pending step dropped
    end else if (phase == PH_DN2) begin
      ctl.stepDn = 1'b1;
      ctl.memEn  = 1'b1;
    end else if (phase == PH_UP2) begin
      ctl.stepUp = 1'b1;
      ctl.memEn  = 1'b1;
    end else if (oneStrobe) begin
      ctl.memEn = 1'b1;
      if (pushByte || pushWord) ctl.stepDn = 1'b1;
      else                      ctl.stepUp = 1'b1;
      if (pushWord)     phaseNext = PH_DN2;
      else if (popWord) phaseNext = PH_UP2;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      phase  <= PH_IDLE;
      errReg <= 1'b0;
    end else begin
      phase <= phaseNext;
      if (clash) errReg <= 1'b1;
    end
  end

  assign busy     = (phase != PH_IDLE);
  assign multiErr = errReg;

endmodule

// File: rtl/stackPtrPath.sv
module stackPtrPath
  import stackPkg::*;
#(
  parameter int PTR_W     = 16,
  parameter int IMPL_BITS = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  stackCtl_t        ctl,
  input  logic             ioSel,
  input  logic [7:0]       ioWrData,
  output logic [PTR_W-1:0] spValue,
  output logic [PTR_W-1:0] memAddr,
  output logic             memWrite,
  output logic [7:0]       ioRdData
);

  localparam int NUM_BYTES = PTR_W / 8;

  function automatic logic [PTR_W-1:0] implMask();
    logic [PTR_W-1:0] m;
    for (int i = 0; i < PTR_W; i++) m[i] = (i < IMPL_BITS);
    return m;
  endfunction

  localparam logic [PTR_W-1:0] IMPL_MASK = implMask();

  logic [PTR_W-1:0] spReg, spNext, loadVal, spPlus, spMinus;

  // Per-byte software load: only the selected byte changes.
  for (genvar g = 0; g < NUM_BYTES; g++) begin : gByte
    assign loadVal[g*8 +: 8] = (ioSel == g[0]) ? ioWrData : spReg[g*8 +: 8];
  end

  assign spPlus  = (spReg + PTR_W'(1)) & IMPL_MASK;
  assign spMinus = (spReg - PTR_W'(1)) & IMPL_MASK;

  always_comb begin
    if (ctl.load)        spNext = loadVal & IMPL_MASK;
    else if (ctl.stepDn) spNext = spMinus;
    else if (ctl.stepUp) spNext = spPlus;
    else                 spNext = spReg;
  end

  always_ff @(posedge clk) begin
    if (!rstN) spReg <= '0;
    else       spReg <= spNext;
  end

  assign spValue  = spReg;
  assign memAddr  = ctl.stepUp ? spPlus : spReg;
  assign memWrite = ctl.stepDn;
  assign ioRdData = ioSel ? spReg[15:8] : spReg[7:0];

endmodule

// File: rtl/stackPointerUnit.sv
module stackPointerUnit
  import stackPkg::*;
#(
  parameter int          IMPL_BITS = 16,
  parameter logic [15:0] LOW_LIMIT = 16'h0060
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        pushByte,
  input  logic        popByte,
  input  logic        pushWord,
  input  logic        popWord,
  input  logic        ioWrEn,
  input  logic        ioSel,
  input  logic [7:0]  ioWrData,
  output logic [7:0]  ioRdData,
  output logic [15:0] memAddr,
  output logic        memValid,
  output logic        memWrite,
  output logic [15:0] spValue,
  output logic        busy,
  output logic        lowStack,
  output logic        multiErr
);

  stackCtl_t ctl;

  stackPtrCtrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .pushByte (pushByte),
    .popByte  (popByte),
    .pushWord (pushWord),
    .popWord  (popWord),
    .ioWrEn   (ioWrEn),
    .ctl      (ctl),
    .busy     (busy),
    .multiErr (multiErr)
  );

  stackPtrPath #(.PTR_W(16), .IMPL_BITS(IMPL_BITS)) u_path (
    .clk      (clk),
    .rstN     (rstN),
    .ctl      (ctl),
    .ioSel    (ioSel),
    .ioWrData (ioWrData),
    .spValue  (spValue),
    .memAddr  (memAddr),
    .memWrite (memWrite),
    .ioRdData (ioRdData)
  );

  assign memValid = ctl.memEn;
  assign lowStack = (spValue <= LOW_LIMIT);

endmodule

// File: rtl/stackPointerChecker.sv
module stackPointerChecker (
  input logic        clk,
  input logic        rstN,
  input logic        pushByte,
  input logic        popByte,
  input logic        pushWord,
  input logic        popWord,
  input logic        ioWrEn,
  input logic        memValid,
  input logic        memWrite,
  input logic [15:0] spValue,
  input logic        busy,
  input logic        multiErr
);

  logic [3:0] strobes;
  assign strobes = {pushByte, popByte, pushWord, popWord};

  // R2 / R4: every push access lowers the pointer by one
  a_r2_push_lowers: assert property (@(posedge clk) disable iff (!rstN)
    memValid && memWrite |=> spValue == 16'($past(spValue) - 16'd1));

  // R3 / R5: every pop access raises the pointer by one
  a_r3_pop_raises: assert property (@(posedge clk) disable iff (!rstN)
    memValid && !memWrite |=> spValue == 16'($past(spValue) + 16'd1));

  // R4: lone two-byte strobe from idle leads to a busy cycle
  a_r4_word_busy: assert property (@(posedge clk) disable iff (!rstN)
    (pushWord || popWord) && $countones(strobes) == 1 && !ioWrEn && !busy |=> busy);

  // R7: software write blocks memory access
  a_r7_io_no_mem: assert property (@(posedge clk) disable iff (!rstN)
    ioWrEn |-> !memValid);

  // R9: conflicting strobes change nothing
  a_r9_clash_noop: assert property (@(posedge clk) disable iff (!rstN)
    $countones(strobes) > 1 && !ioWrEn && !busy |=> $stable(spValue));

  // R9: error is sticky
  a_r9_err_sticky: assert property (@(posedge clk) disable iff (!rstN)
    multiErr |=> multiErr);

  // R11: no second busy cycle in a row
  a_r11_busy_single: assert property (@(posedge clk) disable iff (!rstN)
    busy |=> !busy);

endmodule

bind stackPointerUnit stackPointerChecker u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .pushByte (pushByte),
  .popByte  (popByte),
  .pushWord (pushWord),
  .popWord  (popWord),
  .ioWrEn   (ioWrEn),
  .memValid (memValid),
  .memWrite (memWrite),
  .spValue  (spValue),
  .busy     (busy),
  .multiErr (multiErr)
);

// File: tb/stackPointerUnit_bench.sv
module stackPointerUnit_bench;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        pushByte = 0, popByte = 0, pushWord = 0, popWord = 0;
  logic        ioWrEn = 0, ioSel = 0;
  logic [7:0]  ioWrData = 0;
  logic [7:0]  ioRdData;
  logic [15:0] memAddr, spValue;
  logic        memValid, memWrite, busy, lowStack, multiErr;

  int nChecks = 0;
  int nFails  = 0;

  // reference state
  int refSp    = 0;
  int refPhase = 0;   // 0 idle, 1 second push step, 2 second pop step
  int refErr   = 0;

  always #4 clk = ~clk;   // 125 MHz

  stackPointerUnit u_stackPointerUnit (
    .clk(clk), .rstN(rstN),
    .pushByte(pushByte), .popByte(popByte), .pushWord(pushWord), .popWord(popWord),
    .ioWrEn(ioWrEn), .ioSel(ioSel), .ioWrData(ioWrData), .ioRdData(ioRdData),
    .memAddr(memAddr), .memValid(memValid), .memWrite(memWrite),
    .spValue(spValue), .busy(busy), .lowStack(lowStack), .multiErr(multiErr)
  );

  task automatic chk(input string tag, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // One cycle: drive after negedge, compare before posedge, advance model.
  task automatic cyc(input bit pb, input bit qb, input bit pw, input bit qw,
                     input bit io = 0, input bit sel = 0, input int dat = 0);
    int n, eValid, eWrite, eAddr, nextSp, nextPhase;
    @(negedge clk);
    pushByte = pb; popByte = qb; pushWord = pw; popWord = qw;
    ioWrEn = io; ioSel = sel; ioWrData = 8'(dat);
    #2;
    n = pb + qb + pw + qw;
    eValid = 0; eWrite = 0; eAddr = -1;
    nextSp = refSp; nextPhase = 0;
    if (io) begin
      if (sel) nextSp = (refSp & 'h00FF) | ((dat & 'hFF) << 8);
      else     nextSp = (refSp & 'hFF00) | (dat & 'hFF);
    end else if (refPhase == 1) begin
      eValid = 1; eWrite = 1; eAddr = refSp; nextSp = (refSp - 1) & 'hFFFF;
    end else if (refPhase == 2) begin
      nextSp = (refSp + 1) & 'hFFFF; eValid = 1; eAddr = nextSp;
    end else if (n == 1) begin
      eValid = 1;
      if (pb || pw) begin
        eWrite = 1; eAddr = refSp; nextSp = (refSp - 1) & 'hFFFF;
        if (pw) nextPhase = 1;
      end else begin
        nextSp = (refSp + 1) & 'hFFFF; eAddr = nextSp;
        if (qw) nextPhase = 2;
      end
    end
    chk("R2/R3/R7/R9/R11 memValid", int'(memValid), eValid);
    if (eValid) begin
      chk("R2/R3/R4/R5/R8 memAddr", int'(memAddr), eAddr);
      chk("R2/R3 memWrite", int'(memWrite), eWrite);
    end
    chk("R1/R4/R5/R11 spValue", int'(spValue), refSp);
    chk("R4/R5 busy", int'(busy), refPhase != 0);
    chk("R9 multiErr", int'(multiErr), refErr);
    chk("R10 lowStack", int'(lowStack), refSp <= 'h60);
    chk("R6 ioRdData", int'(ioRdData), sel ? (refSp >> 8) : (refSp & 'hFF));
    if (n > 1) refErr = 1;
    refSp = nextSp; refPhase = nextPhase;
  endtask

  task automatic idle(); cyc(0,0,0,0); endtask
  task automatic load(input int v);
    cyc(0,0,0,0,1,1,v >> 8);
    cyc(0,0,0,0,1,0,v & 'hFF);
  endtask

  initial begin
    #(8 * 200000);
    nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rstN = 1'b1;
    idle();                       // R1 reset state
    load('h1000);                 // R6
    cyc(1,0,0,0);                 // R2 byte push
    cyc(0,1,0,0);                 // R3 byte pop
    cyc(0,0,1,0); idle();         // R4 word push
    cyc(0,0,0,1); idle();         // R5 word pop
    cyc(1,0,0,0,1,0,'h44);        // R7 io write beats strobe
    cyc(0,0,1,0); cyc(0,0,0,0,1,1,'h22); idle(); // R7 cancel second step
    cyc(0,0,0,1); cyc(1,0,0,0); idle();          // R11 strobe while busy
    cyc(0,0,0,1); cyc(0,1,1,0); idle();          // R11 clash while busy
    cyc(1,1,0,0); idle();         // R9 clash
    cyc(0,0,1,1); idle();         // R9 sticky
    load('h0061); cyc(1,0,0,0); idle(); cyc(0,1,0,0); idle(); // R10 boundary
    load('h0000); cyc(1,0,0,0); idle();                       // R8 wrap down
    load('hFFFF); cyc(0,0,0,1); idle();                       // R8 wrap up
    load('h0000); cyc(0,0,1,0); idle();                       // R8 word wrap
    for (int i = 0; i < 400; i++) begin
      int r = $urandom_range(0, 15);
      case (r)
        0, 1, 2: cyc(1,0,0,0);
        3, 4, 5: cyc(0,1,0,0);
        6, 7:    cyc(0,0,1,0);
        8, 9:    cyc(0,0,0,1);
        10:      cyc(0,0,0,0,1,$urandom_range(0,1),$urandom_range(0,255));
        11:      cyc(1,0,0,1);
        default: idle();
      endcase
    end
    idle();
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

endmodule